// File: doc/BRIEF.md
# SDLC Frame Receiver with Address Filter

This block takes a serial bit stream that has already been line-decoded and clock-recovered. A one-cycle `bit_en` strobe qualifies each bit. The block hunts for the opening flag and deletes the zero bits the sender inserted for transparency. It packs the remaining bits into bytes, least significant bit first, and runs the 16-bit frame check sequence over every byte of the frame. The closing flag ends the frame. A run of seven ones aborts it.

The first byte of a frame is its address. With address search turned on, the frame is passed only if that byte equals the node address on `node_addr` or the all-ones broadcast value. Any other frame is swallowed whole. With search turned off, every frame is passed. Passed bytes leave on a simple valid/last stream. The two check bytes are never put on the stream. Status flags for check-sequence result and abort are valid on the beat that carries `out_last`.

A byte is released only after three later bytes of the same frame have arrived. This lets the block hold back the check bytes and drop frames that are too short without ever starting them.

Top module: `sdlc_rx_filter`

## Requirements
- R1: Bytes are assembled least significant bit first between an opening and a closing flag (0x7E). The address byte and all data bytes come out in order. The two check bytes are withheld. `out_last` marks the final data byte.
- R2: After five consecutive ones, a following zero is removed from the data. This holds for stuffed zeros inside payload bytes such as 0xFF and 0x7E.
- R3: The check register starts at all ones for each frame. On the last beat, `out_crc_ok` is 1 only if the residue after the check bytes is 0xF0B8 and the frame holds a whole number of bytes.
- R4: With `search_en`=1, a frame whose first byte equals `node_addr` or 0xFF is delivered.
- R5: With `search_en`=0, every frame of at least four bytes is delivered, whatever its first byte.
- R6: With `search_en`=1, a frame whose first byte matches neither address produces no beat at all, including no end beat.
- R7: A frame with fewer than four bytes between flags produces no beat.
- R8: Seven consecutive ones abort the frame, and the byte in progress is discarded with it. If any beat of that frame was already sent, one extra beat follows with `out_last`=1, `out_abort`=1 and data 0x00. The block then waits for a flag.
- R9: A byte is sent once three further bytes of its frame have been completed. A frame aborted after k complete bytes (k ≥ 4) therefore shows k−3 data beats before its abort beat.
- R10: After reset, `out_valid` is 0. Bits received before the first flag produce no output.
- R11: Frames are received correctly when `bit_en` is high on every clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies `bit_in` for one cycle |
| bit_in | input | 1 | Decoded serial line bit |
| search_en | input | 1 | 1 enables address filtering |
| node_addr | input | 8 | Own station address |
| out_valid | output | 1 | A beat is present this cycle |
| out_data | output | 8 | Delivered byte (0x00 on an abort beat) |
| out_last | output | 1 | Final beat of a frame |
| out_crc_ok | output | 1 | Check sequence good (valid with `out_last`) |
| out_abort | output | 1 | Frame was aborted (valid with `out_last`) |

## Verification
A table of frames covers the address decision. It includes a node-address match, a miss and a broadcast with search on, a miss with search off, a corrupted check field, and a frame of address plus check bytes only. Together these separate filtering from short-frame suppression and good check results from bad ones. Payloads of 0xFF, 0x7E and 0xF8 force stuffed zeros, both with a gap between bits and with `bit_en` held high. Directed frames cover two cases: an abort before and after the first byte is released, and a frame with three extra bits before its closing flag. Line noise before the first flag is also sent, to show that flag hunting works.

// File: rtl/sdlc_rx_pkg.sv
package sdlc_rx_pkg;

    localparam int BYTE_W     = 8;
    localparam int BITCNT_W   = $clog2(BYTE_W);
    localparam int FLAG_LEN   = 8;
    localparam int ONES_STUFF = 5;
    localparam int ONES_FLAG  = 6;
    localparam int CRC_W      = 16;

    localparam logic [CRC_W-1:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_RV = 16'h8408;
    localparam logic [CRC_W-1:0] CRC_RESIDUE = 16'hF0B8;

    typedef logic [BYTE_W-1:0] byte_t;

    // one destuffed data bit leaving the flag-alignment delay
    typedef struct packed {
        logic v;
        logic b;
    } dbit_t;

    // byte-level events towards the frame controller
    typedef struct packed {
        logic  byte_v;
        byte_t data;
        logic  end_v;
        logic  end_ok;
        logic  abt_v;
    } asm_evt_t;

    // bit-serial CRC-16, reflected polynomial, LSB first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_POLY_RV : '0);
    endfunction

endpackage

// File: rtl/sdlc_rx_front.sv
module sdlc_rx_front
    import sdlc_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_en,
    input  logic  bit_in,
    output dbit_t dbit_o,
    output logic  flag_o,
    output logic  abort_o
);

    logic [FLAG_LEN-1:0] raw_q;    // last FLAG_LEN raw bits, [0] newest
    logic [FLAG_LEN-1:0] keep_q;   // bit is data (not stuffed, not flag)
    logic [2:0]          ones_q;   // saturating run of ones

    logic is_stuff, is_flag, is_abort;

    always_comb begin
        is_stuff = !bit_in && (ones_q == 3'(ONES_STUFF));
        is_flag  = !bit_in && (ones_q == 3'(ONES_FLAG));
        is_abort =  bit_in && (ones_q == 3'(ONES_FLAG));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q   <= '0;
            keep_q  <= '0;
            ones_q  <= '0;
            dbit_o  <= '0;
            flag_o  <= 1'b0;
            abort_o <= 1'b0;
        end else begin
            dbit_o.v <= 1'b0;
            flag_o   <= 1'b0;
            abort_o  <= 1'b0;
            if (bit_en) begin
                raw_q  <= {raw_q[FLAG_LEN-2:0], bit_in};
                keep_q <= (is_flag || is_abort) ? '0 : {keep_q[FLAG_LEN-2:0], !is_stuff};
                if (bit_in)
                    ones_q <= (ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1;
                else
                    ones_q <= '0;
                // the bit leaving the delay precedes any flag now completing
                dbit_o.v <= keep_q[FLAG_LEN-1] && !is_abort;
                dbit_o.b <= raw_q[FLAG_LEN-1];
                flag_o   <= is_flag;
                abort_o  <= is_abort;
            end
        end
    end

    // R8: an abort leaves no buffered bit eligible as data
    a_r8_abort_flushes: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> (keep_q == '0));

    // R1: flag and abort never reported together
    a_r1_flag_abort_excl: assert property (@(posedge clk) disable iff (rst)
        !(flag_o && abort_o));

endmodule

// File: rtl/sdlc_rx_asm.sv
module sdlc_rx_asm
    import sdlc_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dbit_t    dbit_i,
    input  logic     flag_i,
    input  logic     abort_i,
    output asm_evt_t evt_o
);

    byte_t               sr_q, sr_n;
    logic [BITCNT_W-1:0] cnt_q, cnt_n;
    logic [CRC_W-1:0]    crc_q, crc_n;
    logic                done;

    always_comb begin
        sr_n  = sr_q;
        cnt_n = cnt_q;
        crc_n = crc_q;
        if (dbit_i.v) begin
            sr_n  = {dbit_i.b, sr_q[BYTE_W-1:1]};
            cnt_n = cnt_q + 1'b1;
            crc_n = crc_step(crc_q, dbit_i.b);
        end
        done = dbit_i.v && (cnt_q == BITCNT_W'(BYTE_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
            crc_q <= CRC_PRESET;
            evt_o <= '0;
        end else begin
            evt_o.byte_v <= done;
            evt_o.data   <= sr_n;
            evt_o.end_v  <= flag_i;
            evt_o.end_ok <= (crc_n == CRC_RESIDUE) && (cnt_n == '0);
            evt_o.abt_v  <= abort_i;
            sr_q <= sr_n;
            if (flag_i || abort_i) begin
                cnt_q <= '0;
                crc_q <= CRC_PRESET;
            end else begin
                cnt_q <= cnt_n;
                crc_q <= crc_n;
            end
        end
    end

    // R3: each frame begins from the all-ones preset
    a_r3_preset_after_flag: assert property (@(posedge clk) disable iff (rst)
        evt_o.end_v |-> (crc_q == CRC_PRESET && cnt_q == '0));

endmodule

// File: rtl/sdlc_rx_ctl.sv
module sdlc_rx_ctl
    import sdlc_rx_pkg::*;
#(
    parameter int    MIN_BYTES = 4,
    parameter byte_t BCAST     = 8'hFF
) (
    input  logic     clk,
    input  logic     rst,
    input  asm_evt_t evt_i,
    input  logic     search_en,
    input  byte_t    node_addr,
    output logic     out_valid,
    output byte_t    out_data,
    output logic     out_last,
    output logic     out_crc_ok,
    output logic     out_abort
);

    localparam int HOLD  = MIN_BYTES - 1;
    localparam int CNT_W = $clog2(MIN_BYTES + 1);
    localparam logic [CNT_W-1:0] NB_FULL = CNT_W'(MIN_BYTES);
    localparam logic [CNT_W-1:0] NB_HOLD = CNT_W'(HOLD);

    logic             in_frame_q, drop_q;
    logic [CNT_W-1:0] nb_q, nb_after;
    byte_t            hold_q [HOLD];
    byte_t            hold_after [HOLD];
    logic             pend_q, pend_ok_q, pend_abt_q;
    byte_t            pend_data_q;

    logic first, miss, drop_eff, take, emit_byte, close_ok, abt_beat;

    always_comb begin
        take     = evt_i.byte_v && in_frame_q;
        first    = take && (nb_q == '0);
        miss     = search_en && (evt_i.data != node_addr) && (evt_i.data != BCAST);
        drop_eff = drop_q || (first && miss);
        emit_byte = take && (nb_q >= NB_HOLD) && !drop_eff;
        nb_after = (take && nb_q != NB_FULL) ? nb_q + 1'b1 : nb_q;
        for (int i = 0; i < HOLD; i++)
            hold_after[i] = hold_q[i];
        if (take) begin
            hold_after[0] = evt_i.data;
            for (int i = 1; i < HOLD; i++)
                hold_after[i] = hold_q[i-1];
        end
        close_ok = evt_i.end_v && in_frame_q && !drop_eff && (nb_after == NB_FULL);
        abt_beat = evt_i.abt_v && in_frame_q && !drop_q && (nb_q == NB_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q  <= 1'b0;
            drop_q      <= 1'b0;
            nb_q        <= '0;
            pend_q      <= 1'b0;
            pend_ok_q   <= 1'b0;
            pend_abt_q  <= 1'b0;
            pend_data_q <= '0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_last    <= 1'b0;
            out_crc_ok  <= 1'b0;
            out_abort   <= 1'b0;
            for (int i = 0; i < HOLD; i++)
                hold_q[i] <= '0;
        end else begin
            out_valid <= 1'b0;
            if (pend_q) begin
                out_valid  <= 1'b1;
                out_data   <= pend_data_q;
                out_last   <= 1'b1;
                out_crc_ok <= pend_ok_q;
                out_abort  <= pend_abt_q;
                pend_q     <= 1'b0;
            end else if (emit_byte) begin
                out_valid  <= 1'b1;
                out_data   <= hold_q[HOLD-1];
                out_last   <= 1'b0;
                out_crc_ok <= 1'b0;
                out_abort  <= 1'b0;
            end
            for (int i = 0; i < HOLD; i++)
                hold_q[i] <= hold_after[i];
            if (evt_i.end_v) begin
                in_frame_q  <= 1'b1;
                drop_q      <= 1'b0;
                nb_q        <= '0;
                pend_q      <= close_ok;
                pend_data_q <= hold_after[HOLD-1];
                pend_ok_q   <= evt_i.end_ok;
                pend_abt_q  <= 1'b0;
            end else if (evt_i.abt_v) begin
                in_frame_q  <= 1'b0;
                drop_q      <= 1'b0;
                nb_q        <= '0;
                pend_q      <= abt_beat;
                pend_data_q <= '0;
                pend_ok_q   <= 1'b0;
                pend_abt_q  <= 1'b1;
            end else begin
                nb_q   <= nb_after;
                drop_q <= drop_eff;
            end
        end
    end

    // R6: a rejected frame stays silent
    a_r6_drop_silent: assert property (@(posedge clk) disable iff (rst)
        drop_q |=> !out_valid);

    // R7: a frame ending before the hold is full emits nothing
    a_r7_short_silent: assert property (@(posedge clk) disable iff (rst)
        (evt_i.end_v && nb_q < NB_HOLD) |=> !out_valid);

    // R3: good-check status only on a normal final beat
    a_r3_ok_on_last: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_crc_ok) |-> (out_last && !out_abort));

    // R8: abort beat is final and carries zero data
    a_r8_abort_beat: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_abort) |-> (out_last && out_data == '0));

    // R10: quiet right after reset
    a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

endmodule

// File: rtl/sdlc_rx_filter.sv
module sdlc_rx_filter
    import sdlc_rx_pkg::*;
#(
    parameter int         MIN_FRAME_BYTES = 4,
    parameter logic [7:0] BCAST_ADDR      = 8'hFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       search_en,
    input  logic [7:0] node_addr,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       out_crc_ok,
    output logic       out_abort
);

    dbit_t    dbit;
    logic     flag_p, abort_p;
    asm_evt_t evt;

    sdlc_rx_front u_front (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .dbit_o  (dbit),
        .flag_o  (flag_p),
        .abort_o (abort_p)
    );

    sdlc_rx_asm u_asm (
        .clk     (clk),
        .rst     (rst),
        .dbit_i  (dbit),
        .flag_i  (flag_p),
        .abort_i (abort_p),
        .evt_o   (evt)
    );

    sdlc_rx_ctl #(
        .MIN_BYTES (MIN_FRAME_BYTES),
        .BCAST     (BCAST_ADDR)
    ) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .search_en  (search_en),
        .node_addr  (node_addr),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .out_crc_ok (out_crc_ok),
        .out_abort  (out_abort)
    );

endmodule

// File: tb/sdlc_rx_filter_tb.sv
`timescale 1ns/1ps
module sdlc_rx_filter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b1;
    logic       search_en = 1'b0;
    logic [7:0] node_addr = 8'h5A;
    logic       out_valid, out_last, out_crc_ok, out_abort;
    logic [7:0] out_data;

    always #2 clk = ~clk;

    sdlc_rx_filter u_dut (
        .clk (clk), .rst (rst), .bit_en (bit_en), .bit_in (bit_in),
        .search_en (search_en), .node_addr (node_addr),
        .out_valid (out_valid), .out_data (out_data), .out_last (out_last),
        .out_crc_ok (out_crc_ok), .out_abort (out_abort)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // received beats
    logic [7:0] rx_data [64];
    logic       rx_last [64];
    logic       rx_ok   [64];
    logic       rx_abt  [64];
    int         rx_n = 0;

    always @(negedge clk) begin
        if (out_valid && rx_n < 64) begin
            rx_data[rx_n] = out_data;
            rx_last[rx_n] = out_last;
            rx_ok[rx_n]   = out_crc_ok;
            rx_abt[rx_n]  = out_abort;
            rx_n = rx_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---- line driver ----
    int         gap = 3;
    int         ones_run = 0;
    logic [15:0] bcrc;

    task automatic send_raw(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_en = 1'b1;
        repeat (gap) begin
            @(negedge clk);
            bit_en = 1'b0;
        end
    endtask

    task automatic line_idle();
        @(negedge clk);
        bit_en = 1'b0;
        bit_in = 1'b1;
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        repeat (6) send_raw(1'b1);
        send_raw(1'b0);
        ones_run = 0;
    endtask

    task automatic send_dbit(input logic b);
        send_raw(b);
        if (b) ones_run++; else ones_run = 0;
        if (ones_run == 5) begin
            send_raw(1'b0);
            ones_run = 0;
        end
    endtask

    function automatic logic [15:0] tb_crc(input logic [15:0] c, input logic b);
        logic [15:0] r;
        r = {1'b0, c[15:1]};
        if (c[0] ^ b) r = r ^ 16'h8408;
        return r;
    endfunction

    task automatic send_byte(input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            bcrc = tb_crc(bcrc, d[i]);
            send_dbit(d[i]);
        end
    endtask

    logic [7:0] fb [16];
    int         fn;

    // flag, bytes, FCS (optionally corrupted), extra bits, closing flag
    task automatic send_frame(input bit bad, input int extra_bits);
        logic [15:0] fcs;
        send_flag();
        bcrc = 16'hFFFF;
        for (int i = 0; i < fn; i++) send_byte(fb[i]);
        fcs = ~bcrc;
        if (bad) fcs[3] = ~fcs[3];
        for (int i = 0; i < 16; i++) send_dbit(fcs[i]);
        for (int i = 0; i < extra_bits; i++) send_dbit(1'b0);
        send_flag();
        line_idle();
        repeat (20) @(negedge clk);
    endtask

    // ---- vector table ----
    typedef struct packed {
        logic       search;
        logic [7:0] addr;
        logic [2:0] ndata;
        logic       bad;
        logic       acc;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h5A, 3'd2, 1'b0, 1'b1},   // node match          R4
        '{1'b1, 8'h33, 3'd2, 1'b0, 1'b0},   // miss, search on     R6
        '{1'b1, 8'hFF, 3'd1, 1'b0, 1'b1},   // broadcast           R4
        '{1'b0, 8'h33, 3'd3, 1'b0, 1'b1},   // search off          R5
        '{1'b1, 8'h5A, 3'd3, 1'b1, 1'b1},   // corrupted FCS       R3
        '{1'b0, 8'h7E, 3'd1, 1'b0, 1'b1},   // flag-like address   R2
        '{1'b1, 8'h5A, 3'd0, 1'b0, 1'b0}    // addr + FCS only     R7
    };

    function automatic logic [7:0] pay(input int v, input int i);
        logic [7:0] stuffy [3];
        stuffy = '{8'hFF, 8'h7E, 8'hF8};
        if (v % 2 == 1) return stuffy[i];
        return 8'(8'h11 * (v + 1) + i);
    endfunction

    task automatic check_frame(input string req, input int exp_n, input bit exp_ok);
        check(rx_n == exp_n, req, "beat count", rx_n, exp_n);
        if (rx_n == exp_n) begin
            for (int i = 0; i < exp_n; i++) begin
                check(rx_data[i] == fb[i], "R1", "byte", rx_data[i], fb[i]);
                check(rx_last[i] == (i == exp_n - 1), "R1", "last", rx_last[i], i == exp_n - 1);
                check(!rx_abt[i], "R8", "abort flag", rx_abt[i], 0);
            end
            if (exp_n > 0)
                check(rx_ok[exp_n-1] == exp_ok, "R3", "crc status", rx_ok[exp_n-1], exp_ok);
        end
    endtask

    initial begin
        string req;
        int    exp_n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);

        // R10: noise before any flag yields nothing
        for (int i = 0; i < 24; i++) send_raw(i[0] ^ i[2]);
        line_idle();
        repeat (10) @(negedge clk);
        check(rx_n == 0, "R10", "beats before first flag", rx_n, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            search_en = VEC[v].search;
            fn = 1 + int'(VEC[v].ndata);
            fb[0] = VEC[v].addr;
            for (int i = 0; i < int'(VEC[v].ndata); i++) fb[i+1] = pay(v, i);
            rx_n = 0;
            send_frame(VEC[v].bad, 0);
            if (!VEC[v].acc && VEC[v].ndata == 0) req = "R7";
            else if (!VEC[v].acc)                req = "R6";
            else if (!VEC[v].search)             req = "R5";
            else                                 req = "R4";
            exp_n = VEC[v].acc ? fn : 0;
            check_frame(req, exp_n, !VEC[v].bad);
        end

        // R11 + R2: continuous bit_en with stuffing-heavy payload
        gap = 0;
        search_en = 1'b1;
        fb[0] = 8'h5A; fb[1] = 8'hFF; fb[2] = 8'h7E; fb[3] = 8'h3F; fn = 4;
        rx_n = 0;
        send_frame(1'b0, 0);
        check_frame("R11", 4, 1'b1);
        gap = 3;

        // R3: three stray bits before closing flag -> bad status
        search_en = 1'b0;
        fb[0] = 8'h21; fb[1] = 8'h42; fn = 2;
        rx_n = 0;
        send_frame(1'b0, 3);
        check_frame("R3", 2, 1'b0);

        // R8/R9: abort after six sent bytes (last one lost) -> two beats + abort
        rx_n = 0;
        send_flag();
        bcrc = 16'hFFFF;
        fb[0] = 8'h10; fb[1] = 8'h20; fb[2] = 8'h30; fb[3] = 8'h40; fb[4] = 8'h50; fb[5] = 8'h00;
        for (int i = 0; i < 6; i++) send_byte(fb[i]);
        repeat (8) send_raw(1'b1);
        line_idle();
        repeat (20) @(negedge clk);
        check(rx_n == 3, "R9", "beats on abort", rx_n, 3);
        if (rx_n == 3) begin
            check(rx_data[0] == 8'h10 && !rx_last[0], "R9", "first byte", rx_data[0], 8'h10);
            check(rx_data[1] == 8'h20 && !rx_last[1], "R9", "second byte", rx_data[1], 8'h20);
            check(rx_last[2] && rx_abt[2], "R8", "abort beat flags", {rx_last[2], rx_abt[2]}, 3);
            check(rx_data[2] == 8'h00 && !rx_ok[2], "R8", "abort beat data", rx_data[2], 0);
        end

        // R8: ones after abort do not resume; next flag needed
        rx_n = 0;
        repeat (10) send_raw(1'b1);
        line_idle();
        repeat (10) @(negedge clk);
        check(rx_n == 0, "R8", "idle ones after abort", rx_n, 0);

        // R8: abort before any beat released -> silent
        rx_n = 0;
        send_flag();
        bcrc = 16'hFFFF;
        send_byte(8'h5A);
        send_byte(8'h00);
        repeat (8) send_raw(1'b1);
        line_idle();
        repeat (20) @(negedge clk);
        check(rx_n == 0, "R8", "early abort beats", rx_n, 0);

        // recovery after abort: next frame normal
        search_en = 1'b1;
        fb[0] = 8'hFF; fb[1] = 8'h99; fn = 2;
        rx_n = 0;
        send_frame(1'b0, 0);
        check_frame("R1", 2, 1'b1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule